// File: doc/BRIEF.md
# Raw Event Framer

The block sits on the raw-data path just in front of a serializer. The incoming words carry no link control symbols, so an event ends when a word equal to a fixed marker value (the parameter `EOE_MARK`) arrives. The raw payload is Gray coded, and the block converts every payload word to binary before passing it on. The marker word itself is consumed and is never forwarded.

On each marker the block emits a closing sequence of three beats. The first is a trailer word that carries the number of payload words in the event just closed. The second is an end beat, which raises the end-of-transmission strobe for the serializer. The third is the header of the next event, sent at once even if none of that event's data has arrived. Each header carries a bunch-crossing number counted locally from a crossing-clock tick, and a resync input clears that count. The first header goes out straight after reset.

Both streams use valid/ready. A word moves on a cycle where valid and ready are both high. Once `o_valid` is raised it stays high, with its beat unchanged, until `o_ready` takes it. `i_ready` follows `o_ready` combinationally, through a one-word skid register. While the block is sending a trailer, end or header beat, that register can still take one input word, so no word is lost.

Top module: `rawevt_framer`

## Requirements
- R1: After reset the block presents a header beat (`o_kind`=1) with data 0 and holds `i_ready` high.
- R2: A non-marker input word is output as a payload beat (`o_kind`=0), with data equal to the Gray-to-binary conversion of the input word (bit i is the XOR of input bits i and up). Payload beats keep the order of their input words.
- R3: An input word equal to `EOE_MARK` is never output as payload. It causes a trailer beat (`o_kind`=2) whose data is the number of payload beats accepted since the last header.
- R4: A trailer beat is followed by an end beat (`o_kind`=3, data 0, `o_eot`=1). `o_eot` is low on every other beat.
- R5: An end beat is followed at once by a header beat, whatever the state of the input.
- R6: The crossing count rises by one, modulo 2^`BX_W`, on each cycle with `i_bx_tick` high. A header's data is the count as it stood in the cycle its preceding end beat was accepted.
- R7: `i_resync` clears the crossing count on the next edge and takes priority over `i_bx_tick`.
- R8: While `o_valid` is high and `o_ready` is low, the next cycle keeps `o_valid` high and keeps `o_data`, `o_kind` and `o_eot` unchanged.
- R9: `i_ready` is low only while the skid register is full and is not being emptied in the same cycle. Every accepted word appears exactly once, as payload or as a consumed marker.
- R10: The payload count restarts from zero when a header beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Input word valid |
| i_ready | output | 1 | Block can take an input word |
| i_data | input | DATA_W | Raw Gray-coded input word or marker |
| i_bx_tick | input | 1 | Crossing-clock tick |
| i_resync | input | 1 | Clear the crossing count |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream takes the beat |
| o_data | output | DATA_W | Payload (binary), trailer count, header crossing number, or 0 |
| o_kind | output | 2 | 0 payload, 1 header, 2 trailer, 3 end |
| o_eot | output | 1 | End-of-transmission strobe, high with the end beat |

## Verification
An input word accepted at one edge can be seen as a payload beat straight after that edge. A marker accepted at one edge is consumed at the next edge, and the trailer is visible after that edge. The end beat and the header each follow one edge after the previous beat is accepted. `i_ready` and payload `o_valid` respond in the same cycle as `o_ready`, and a tick or resync shows up in the first header captured after the edge that applied it. The bench sets all inputs just after the falling edge and samples one time step later. It predicts every output from a behavioural model that it advances only at the rising edge, so each compare falls in exactly the cycle where the result is due.

// File: rtl/rawevt_pkg.sv
package rawevt_pkg;
  typedef enum logic [1:0] {
    K_PAY = 2'd0,
    K_HDR = 2'd1,
    K_TRL = 2'd2,
    K_END = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_TRL  = 2'd2,
    ST_END  = 2'd3
  } fstate_t;
endpackage

// File: rtl/rawevt_gray2bin.sv
module rawevt_gray2bin #(
  parameter int W = 16
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/rawevt_bxcnt.sv
module rawevt_bxcnt #(
  parameter int BX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            resync,
  output logic [BX_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (resync) count <= '0;
    else if (tick)   count <= count + 1'b1;
  end
endmodule

// File: rtl/rawevt_seq.sv
module rawevt_seq
  import rawevt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_v,
  input  logic              hold_mark,
  input  logic [DATA_W-1:0] pay_bin,
  input  logic [BX_W-1:0]   bx_cnt,
  input  logic              o_ready,
  output logic              o_valid,
  output logic [1:0]        o_kind,
  output logic [DATA_W-1:0] o_data,
  output logic              o_eot,
  output logic              drain,
  output logic [DATA_W-1:0] pay_cnt
);
  fstate_t           st;
  logic [BX_W-1:0]   hdr_q;
  logic              fire;

  always_comb begin
    o_valid = 1'b1;
    o_kind  = K_HDR;
    o_data  = DATA_W'(hdr_q);
    o_eot   = 1'b0;
    drain   = 1'b0;
    case (st)
      ST_DATA: begin
        o_kind  = K_PAY;
        o_data  = pay_bin;
        o_valid = hold_v && !hold_mark;
        drain   = hold_v && (hold_mark || o_ready);
      end
      ST_TRL: begin
        o_kind = K_TRL;
        o_data = pay_cnt;
      end
      ST_END: begin
        o_kind = K_END;
        o_data = '0;
        o_eot  = 1'b1;
      end
      default: ;
    endcase
  end

  assign fire = o_valid && o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HDR;
      hdr_q   <= '0;
      pay_cnt <= '0;
    end else begin
      case (st)
        ST_HDR: if (fire) begin
          st      <= ST_DATA;
          pay_cnt <= '0;
        end
        ST_DATA: begin
          if (hold_v && hold_mark) st <= ST_TRL;
          else if (fire)           pay_cnt <= pay_cnt + 1'b1;
        end
        ST_TRL: if (fire) st <= ST_END;
        ST_END: if (fire) begin
          st    <= ST_HDR;
          hdr_q <= bx_cnt;
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/rawevt_framer.sv
module rawevt_framer #(
  parameter int               DATA_W   = 16,
  parameter int               BX_W     = 8,
  parameter logic [DATA_W-1:0] EOE_MARK = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  output logic              i_ready,
  input  logic [DATA_W-1:0] i_data,
  input  logic              i_bx_tick,
  input  logic              i_resync,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic [1:0]        o_kind,
  output logic              o_eot
);
  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic              hold_mark;
  logic [DATA_W-1:0] pay_bin;
  logic [BX_W-1:0]   bx_cnt;
  logic [DATA_W-1:0] pay_cnt;
  logic              drain;
  logic              take;

  assign hold_mark = (hold_d == EOE_MARK);
  assign i_ready   = !hold_v || drain;
  assign take      = i_valid && i_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else begin
      if (take) begin
        hold_v <= 1'b1;
        hold_d <= i_data;
      end else if (drain) begin
        hold_v <= 1'b0;
      end
    end
  end

  rawevt_gray2bin #(.W(DATA_W)) u_g2b (
    .gray (hold_d),
    .bin  (pay_bin)
  );

  rawevt_bxcnt #(.BX_W(BX_W)) u_bx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (i_bx_tick),
    .resync (i_resync),
    .count  (bx_cnt)
  );

  rawevt_seq #(.DATA_W(DATA_W), .BX_W(BX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_v    (hold_v),
    .hold_mark (hold_mark),
    .pay_bin   (pay_bin),
    .bx_cnt    (bx_cnt),
    .o_ready   (o_ready),
    .o_valid   (o_valid),
    .o_kind    (o_kind),
    .o_data    (o_data),
    .o_eot     (o_eot),
    .drain     (drain),
    .pay_cnt   (pay_cnt)
  );
endmodule

// File: rtl/rawevt_framer_chk.sv
module rawevt_framer_chk #(
  parameter int DATA_W = 16,
  parameter int BX_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_valid,
  input logic              i_ready,
  input logic              i_bx_tick,
  input logic              i_resync,
  input logic              o_valid,
  input logic              o_ready,
  input logic [DATA_W-1:0] o_data,
  input logic [1:0]        o_kind,
  input logic              o_eot,
  input logic              hold_v,
  input logic [BX_W-1:0]   bx_cnt,
  input logic [DATA_W-1:0] pay_cnt
);
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_kind) && $stable(o_eot)));

  p_end_after_trl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && o_kind == 2'd2) |=> (o_valid && o_kind == 2'd3 && o_eot && o_data == '0));

  p_hdr_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && o_eot) |=> (o_valid && o_kind == 2'd1 && !o_eot));

  p_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_bx_tick && !i_resync) |=> (bx_cnt == BX_W'($past(bx_cnt) + 1'b1)));

  p_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    i_resync |=> (bx_cnt == '0));

  p_skid_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready) |=> hold_v);

  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && o_kind == 2'd1) |=> (pay_cnt == '0));
endmodule

bind rawevt_framer rawevt_framer_chk #(.DATA_W(DATA_W), .BX_W(BX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .i_valid   (i_valid),
  .i_ready   (i_ready),
  .i_bx_tick (i_bx_tick),
  .i_resync  (i_resync),
  .o_valid   (o_valid),
  .o_ready   (o_ready),
  .o_data    (o_data),
  .o_kind    (o_kind),
  .o_eot     (o_eot),
  .hold_v    (hold_v),
  .bx_cnt    (bx_cnt),
  .pay_cnt   (pay_cnt)
);

// File: tb/test_rawevt_framer.sv
`timescale 1ns/1ps
module test_rawevt_framer;
  localparam int DATA_W = 16;
  localparam int BX_W   = 8;
  localparam logic [15:0] MARK = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_valid = 1'b0, i_ready;
  logic [15:0] i_data = '0;
  logic i_bx_tick = 1'b0, i_resync = 1'b0;
  logic o_valid, o_ready = 1'b0;
  logic [15:0] o_data;
  logic [1:0] o_kind;
  logic o_eot;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rawevt_framer #(.DATA_W(DATA_W), .BX_W(BX_W), .EOE_MARK(MARK)) i_rawevt_framer (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready), .i_data(i_data),
    .i_bx_tick(i_bx_tick), .i_resync(i_resync), .o_valid(o_valid), .o_ready(o_ready),
    .o_data(o_data), .o_kind(o_kind), .o_eot(o_eot));

  // behavioural model state
  int m_phase;            // 0 header, 1 data, 2 trailer, 3 end
  logic [15:0] m_q[$];
  int m_cnt, m_bx, m_hdr;

  function automatic logic [15:0] g2b(input logic [15:0] g);
    logic [15:0] b = g;
    for (int s = 1; s < 16; s++) b = b ^ (g >> s);
    return b;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic run(input int cycles, input int pv, input int pm, input int pr,
                     input int pt, input int ps);
    for (int c = 0; c < cycles; c++) begin
      bit front, mark, e_valid, e_ready, fire, drain, acc;
      int e_kind; logic [15:0] e_data;
      @(negedge clk);
      i_valid   = ($urandom % 100) < pv;
      if (($urandom % 100) < pm) i_data = MARK;
      else begin
        i_data = 16'($urandom);
        if (i_data == MARK) i_data = 16'h1234;
      end
      o_ready   = ($urandom % 100) < pr;
      i_bx_tick = ($urandom % 100) < pt;
      i_resync  = ($urandom % 100) < ps;
      #1;
      front   = m_q.size() > 0;
      mark    = front && m_q[0] == MARK;
      e_valid = (m_phase != 1) || (front && !mark);
      e_ready = !front || (m_phase == 1 && (mark || o_ready));
      case (m_phase)
        0: begin e_kind = 1; e_data = 16'(m_hdr); end
        1: begin e_kind = 0; e_data = front ? g2b(m_q[0]) : 16'h0; end
        2: begin e_kind = 2; e_data = 16'(m_cnt); end
        default: begin e_kind = 3; e_data = 16'h0; end
      endcase
      check("R9 i_ready", i_ready, e_ready);
      check("R5 R8 o_valid", o_valid, e_valid);
      if (e_valid) begin
        string tag;
        case (e_kind)
          0: tag = "R2 R3 payload";
          1: tag = "R6 R7 header";
          2: tag = "R3 R10 trailer";
          default: tag = "R4 end";
        endcase
        check({tag, " kind"}, o_kind, e_kind);
        check({tag, " data"}, o_data, e_data);
        check("R4 eot", o_eot, e_kind == 3);
      end
      // next state, from pre-edge values
      fire  = e_valid && o_ready;
      drain = m_phase == 1 && front && (mark || o_ready);
      acc   = i_valid && e_ready;
      @(posedge clk);
      if (m_phase == 3 && fire) m_hdr = m_bx;
      if (i_resync) m_bx = 0;
      else if (i_bx_tick) m_bx = (m_bx + 1) % (1 << BX_W);
      case (m_phase)
        0: if (fire) begin m_phase = 1; m_cnt = 0; end
        1: if (mark) m_phase = 2; else if (fire) m_cnt = (m_cnt + 1) % 65536;
        2: if (fire) m_phase = 3;
        default: if (fire) m_phase = 0;
      endcase
      if (drain) void'(m_q.pop_front());
      if (acc) m_q.push_back(i_data);
    end
  endtask

  initial begin
    m_phase = 0; m_cnt = 0; m_bx = 0; m_hdr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 o_valid", o_valid, 1);
    check("R1 o_kind", o_kind, 1);
    check("R1 o_data", o_data, 0);
    check("R1 i_ready", i_ready, 1);
    run(1500, 90, 3, 100, 20, 0);   // streaming, full rate
    run(1500, 70, 8, 40, 30, 0);    // back-pressure, R8
    run(800,  90, 40, 70, 50, 0);   // near-empty events, count 0
    run(1200, 60, 5, 60, 60, 5);    // resync and wrap, R7
    run(800,  20, 10, 90, 10, 1);   // sparse input
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule